// File: doc/BRIEF.md
# Banked Interrupt Distributor Core

This block keeps the configuration and live state of every interrupt in a small distributor that serves several CPUs (two by default) across 64 interrupt IDs. For each interrupt it holds an enable, a pending flag, an active flag, an 8-bit priority, a security classification, a trigger mode and, for shared interrupts, a mask of target CPUs. IDs below 32 are private: every CPU owns its own copy of their state. Accesses through the register port pick that copy with a CPU-number input. IDs 32 and up are shared and exist once.

Every cycle the block looks at each CPU's view of the interrupt space and finds the best forwardable interrupt. An interrupt is forwardable when it is enabled, pending, not active, allowed by its security group's global switch and, if shared, aimed at that CPU. The best one has the numerically smallest priority. The chosen ID and its priority are registered and handed to that CPU's interface logic. Software-interrupt requests arrive as per-CPU pulses from a separate generator. Acknowledge and end-of-interrupt sequencing happen outside the block, through the active field.

Top module: `intdist_core`

## Requirements
- R1: After reset every interrupt is disabled, not pending, not active, at priority 0 and classed secure. Both global group switches are off. Every CPU is presented ID 1023 with priority 255.
- R2: A read request is answered in the next cycle with `reg_rvalid` high and the value of the selected field, and that value includes any write accepted in an earlier cycle. Field codes: 0 enable, 1 pending (write 1 sets, 0 clears), 2 active, 3 priority, 4 security (1 = secure), 5 trigger (1 = edge), 6 target mask, 7 global switches (bit 0 secure group, bit 1 non-secure group). Single-bit fields use data bit 0.
- R3: For IDs 0–31 all fields are held separately per CPU, and `reg_cpu` chooses which copy an access touches.
- R4: Target-mask writes take effect only for IDs 32 and above. For IDs below 32, a read of the target mask returns a one-hot mask with bit `reg_cpu` set.
- R5: Software set-pending and clear-pending writes have no effect on IDs 0–15. For IDs 16 and above they set or clear the pending flag.
- R6: Trigger-mode writes are ignored for IDs 0–15, which always read back as edge (1). For other IDs the mode is level (0) after reset and can be written.
- R7: An edge-mode interrupt becomes pending on a rising input edge. An input held high does not make it pending again after it has been cleared.
- R8: A level-mode interrupt's pending flag follows its input while the interrupt is not active, and holds its value while active.
- R9: Writing 1 to the active field of an edge-mode or software interrupt also clears its pending flag. An active interrupt is never forwarded.
- R10: Each CPU is presented the forwardable interrupt with the lowest priority value, with ties going to the lower ID. The ID and priority appear one cycle after the state that produced them.
- R11: A CPU with no forwardable interrupt is presented ID 1023 and priority 255.
- R12: An interrupt whose security group has its global switch off is not forwarded to any CPU.
- R13: A software-interrupt request bit `sgi_req[c*16+n]` makes ID n pending in CPU c's private bank only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_cpu | input | CPU_W | Number of the accessing CPU, used to select the private bank |
| reg_id | input | ID_W | Interrupt ID being accessed |
| reg_field | input | 3 | Field code |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the request |
| reg_rvalid | output | 1 | Read data valid |
| sgi_req | input | NUM_CPU*16 | Software-interrupt set pulses, per CPU and per ID |
| ppi_in | input | NUM_CPU*16 | Private peripheral inputs for IDs 16–31, per CPU |
| spi_in | input | NUM_IRQ-32 | Shared peripheral inputs for IDs 32 and up |
| best_id | output | NUM_CPU*10 | Selected interrupt ID per CPU, 1023 when there is none |
| best_prio | output | NUM_CPU*PRIO_W | Priority of the selected interrupt per CPU |

## Verification
The hardest state to reach is a level-mode interrupt that is active while its input drops. Its pending flag must stay frozen at 1 and then fall only once the active flag is released. The bench raises the private input, writes the active field through the register port, drops the input and reads the pending field back. It then clears the active field and reads the flag again. A second hard case is a shared interrupt with its edge input held high after software has cleared it. The bench reaches it by holding the input high across the clear and showing that neither the presented ID nor the pending read changes until the input has toggled.

// File: rtl/intdist_pkg.sv
package intdist_pkg;

   typedef enum logic [2:0] {
      FLD_ENABLE = 3'd0,
      FLD_PEND   = 3'd1,
      FLD_ACTIVE = 3'd2,
      FLD_PRIO   = 3'd3,
      FLD_SECURE = 3'd4,
      FLD_TRIG   = 3'd5,
      FLD_TARGET = 3'd6,
      FLD_GLOBAL = 3'd7
   } field_e;

   localparam int KIND_SGI = 0;
   localparam int KIND_PPI = 1;
   localparam int KIND_SPI = 2;

   localparam int PRIV_IDS = 32;
   localparam int SOFT_IDS = 16;
   localparam int ID_OUT_W = 10;
   localparam logic [ID_OUT_W-1:0] NO_IRQ_ID = 10'd1023;

endpackage

// File: rtl/intdist_slot.sv
module intdist_slot
   import intdist_pkg::*;
#(
   parameter int KIND    = KIND_SPI,
   parameter int PRIO_W  = 8,
   parameter int NUM_CPU = 2,
   parameter int DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  field_e            field,
   input  logic [DATA_W-1:0] wdata,
   input  logic              src,
   output logic              en,
   output logic              pend,
   output logic              act,
   output logic              sec,
   output logic              is_edge,
   output logic [PRIO_W-1:0] prio,
   output logic [NUM_CPU-1:0] tgt
);

   localparam bit PEND_WR_OK = (KIND != KIND_SGI);
   localparam bit TRIG_WR_OK = (KIND != KIND_SGI);
   localparam bit TGT_WR_OK  = (KIND == KIND_SPI);

   logic act_set, sw_set, sw_clr, hw_set, pend_nxt;

   if (KIND == KIND_SGI) begin : g_req
      assign hw_set = src;
   end else begin : g_edge
      logic src_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) src_q <= 1'b0;
         else        src_q <= src;
      end
      assign hw_set = src & ~src_q;
   end

   always_comb begin
      act_set = wr && (field == FLD_ACTIVE) && wdata[0];
      sw_set  = PEND_WR_OK && wr && (field == FLD_PEND) && wdata[0];
      sw_clr  = PEND_WR_OK && wr && (field == FLD_PEND) && !wdata[0];
      if (is_edge) pend_nxt = (pend && !act_set) || hw_set;
      else         pend_nxt = act ? pend : src;
      if (sw_set)      pend_nxt = 1'b1;
      else if (sw_clr) pend_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         pend    <= 1'b0;
         act     <= 1'b0;
         sec     <= 1'b1;
         is_edge <= (KIND == KIND_SGI);
         prio    <= '0;
         tgt     <= '0;
      end else begin
         pend <= pend_nxt;
         if (wr) begin
            case (field)
               FLD_ENABLE: en   <= wdata[0];
               FLD_ACTIVE: act  <= wdata[0];
               FLD_PRIO:   prio <= wdata[PRIO_W-1:0];
               FLD_SECURE: sec  <= wdata[0];
               FLD_TRIG:   if (TRIG_WR_OK) is_edge <= wdata[0];
               FLD_TARGET: if (TGT_WR_OK) tgt <= wdata[NUM_CPU-1:0];
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/intdist_arb.sv
module intdist_arb
   import intdist_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_IRQ-1:0]               elig,
   input  logic [NUM_IRQ-1:0][PRIO_W-1:0]   prio,
   output logic [ID_OUT_W-1:0]              best_id,
   output logic [PRIO_W-1:0]                best_prio
);

   logic                found;
   logic [ID_OUT_W-1:0] win_id;
   logic [PRIO_W-1:0]   win_prio;

   // strict less-than keeps the first (lowest) ID on equal priority
   always_comb begin
      found    = 1'b0;
      win_id   = NO_IRQ_ID;
      win_prio = '1;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (elig[i] && (!found || (prio[i] < win_prio))) begin
            found    = 1'b1;
            win_id   = ID_OUT_W'(i);
            win_prio = prio[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_id   <= NO_IRQ_ID;
         best_prio <= '1;
      end else begin
         best_id   <= win_id;
         best_prio <= win_prio;
      end
   end

endmodule

// File: rtl/intdist_core.sv
module intdist_core
   import intdist_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8,
   parameter int DATA_W  = 8,
   localparam int CPU_W      = $clog2(NUM_CPU),
   localparam int ID_W       = $clog2(NUM_IRQ),
   localparam int NUM_SPI    = NUM_IRQ - PRIV_IDS,
   localparam int PRIV_SLOTS = NUM_CPU * PRIV_IDS,
   localparam int SLOTS      = PRIV_SLOTS + NUM_SPI,
   localparam int SLOT_W     = $clog2(SLOTS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         reg_wr,
   input  logic                         reg_rd,
   input  logic [CPU_W-1:0]             reg_cpu,
   input  logic [ID_W-1:0]              reg_id,
   input  logic [2:0]                   reg_field,
   input  logic [DATA_W-1:0]            reg_wdata,
   output logic [DATA_W-1:0]            reg_rdata,
   output logic                         reg_rvalid,
   input  logic [NUM_CPU*SOFT_IDS-1:0]  sgi_req,
   input  logic [NUM_CPU*SOFT_IDS-1:0]  ppi_in,
   input  logic [NUM_SPI-1:0]           spi_in,
   output logic [NUM_CPU*ID_OUT_W-1:0]  best_id,
   output logic [NUM_CPU*PRIO_W-1:0]    best_prio
);

   // elaboration-time parameter checks
   if (NUM_CPU < 2 || NUM_CPU > DATA_W || (1 << CPU_W) != NUM_CPU) begin : g_bad_cpu
      $error("intdist_core: NUM_CPU must be a power of two between 2 and DATA_W");
   end
   if (NUM_IRQ <= PRIV_IDS || NUM_IRQ > 512 || (1 << ID_W) != NUM_IRQ) begin : g_bad_irq
      $error("intdist_core: NUM_IRQ must be a power of two from 64 to 512");
   end
   if (PRIO_W < 1 || PRIO_W > DATA_W) begin : g_bad_prio
      $error("intdist_core: PRIO_W must lie in 1..DATA_W");
   end

   field_e fld;
   assign fld = field_e'(reg_field);

   logic gen_s, gen_ns;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_s  <= 1'b0;
         gen_ns <= 1'b0;
      end else if (reg_wr && fld == FLD_GLOBAL) begin
         gen_s  <= reg_wdata[0];
         gen_ns <= reg_wdata[1];
      end
   end

   // access decode: private IDs map into the caller's bank
   logic              is_private;
   logic [SLOT_W-1:0] sel_slot;
   assign is_private = reg_id < ID_W'(PRIV_IDS);
   always_comb begin
      if (is_private) sel_slot = (SLOT_W'(reg_cpu) << 5) | SLOT_W'(reg_id[4:0]);
      else            sel_slot = SLOT_W'(PRIV_SLOTS) + SLOT_W'(reg_id) - SLOT_W'(PRIV_IDS);
   end

   logic [SLOTS-1:0]                en_v, pend_v, act_v, sec_v, edge_v;
   logic [SLOTS-1:0][PRIO_W-1:0]    prio_v;
   logic [SLOTS-1:0][NUM_CPU-1:0]   tgt_v;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int LOCAL = s % PRIV_IDS;
      localparam int OWNER = s / PRIV_IDS;
      localparam int KIND  = (s >= PRIV_SLOTS) ? KIND_SPI :
                             ((LOCAL < SOFT_IDS) ? KIND_SGI : KIND_PPI);
      logic src;
      logic slot_wr;
      if (KIND == KIND_SGI) begin : g_sgi
         assign src = sgi_req[OWNER*SOFT_IDS + LOCAL];
      end else if (KIND == KIND_PPI) begin : g_ppi
         assign src = ppi_in[OWNER*SOFT_IDS + LOCAL - SOFT_IDS];
      end else begin : g_spi
         assign src = spi_in[s - PRIV_SLOTS];
      end
      assign slot_wr = reg_wr && (fld != FLD_GLOBAL) && (sel_slot == SLOT_W'(s));

      intdist_slot #(
         .KIND(KIND), .PRIO_W(PRIO_W), .NUM_CPU(NUM_CPU), .DATA_W(DATA_W)
      ) u_slot (
         .clk(clk), .rst_n(rst_n), .wr(slot_wr), .field(fld), .wdata(reg_wdata),
         .src(src), .en(en_v[s]), .pend(pend_v[s]), .act(act_v[s]), .sec(sec_v[s]),
         .is_edge(edge_v[s]), .prio(prio_v[s]), .tgt(tgt_v[s])
      );
   end

   // register read path, one cycle latency
   logic [DATA_W-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      case (fld)
         FLD_ENABLE: rd_val[0] = en_v[sel_slot];
         FLD_PEND:   rd_val[0] = pend_v[sel_slot];
         FLD_ACTIVE: rd_val[0] = act_v[sel_slot];
         FLD_PRIO:   rd_val[PRIO_W-1:0] = prio_v[sel_slot];
         FLD_SECURE: rd_val[0] = sec_v[sel_slot];
         FLD_TRIG:   rd_val[0] = edge_v[sel_slot];
         FLD_TARGET: begin
            if (is_private) rd_val[NUM_CPU-1:0] = NUM_CPU'(1) << reg_cpu;
            else            rd_val[NUM_CPU-1:0] = tgt_v[sel_slot];
         end
         FLD_GLOBAL: rd_val[1:0] = {gen_ns, gen_s};
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd) reg_rdata <= rd_val;
      end
   end

   // per-CPU candidate view and selection
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic [NUM_IRQ-1:0]             elig;
      logic [NUM_IRQ-1:0][PRIO_W-1:0] pv;
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
         localparam int S = (i < PRIV_IDS) ? (c*PRIV_IDS + i) : (PRIV_SLOTS + i - PRIV_IDS);
         logic grp_ok;
         assign grp_ok = sec_v[S] ? gen_s : gen_ns;
         if (i < PRIV_IDS) begin : g_priv
            assign elig[i] = en_v[S] & pend_v[S] & ~act_v[S] & grp_ok;
         end else begin : g_shared
            assign elig[i] = en_v[S] & pend_v[S] & ~act_v[S] & grp_ok & tgt_v[S][c];
         end
         assign pv[i] = prio_v[S];
      end

      intdist_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
         .clk(clk), .rst_n(rst_n), .elig(elig), .prio(pv),
         .best_id(best_id[c*ID_OUT_W +: ID_OUT_W]),
         .best_prio(best_prio[c*PRIO_W +: PRIO_W])
      );
   end

endmodule

// File: rtl/intdist_core_chk.sv
module intdist_core_chk
   import intdist_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int NUM_IRQ = 64,
   parameter int DATA_W  = 8,
   parameter int CPU_W   = 1,
   parameter int ID_W    = 6
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        reg_rd,
   input logic [2:0]                  reg_field,
   input logic [ID_W-1:0]             reg_id,
   input logic [CPU_W-1:0]            reg_cpu,
   input logic [DATA_W-1:0]           reg_rdata,
   input logic                        reg_rvalid,
   input logic [NUM_CPU*ID_OUT_W-1:0] best_id,
   input logic                        gen_s,
   input logic                        gen_ns
);

   assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

   assert_no_stray_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !reg_rvalid);

   assert_global_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_field == 3'd7) |=>
         reg_rdata == {{(DATA_W-2){1'b0}}, $past(gen_ns), $past(gen_s)});

   assert_private_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_field == 3'd6 && reg_id < ID_W'(32)) |=>
         reg_rdata == (DATA_W'(1) << $past(reg_cpu)));

   assert_groups_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!gen_s && !gen_ns) |=> best_id == {NUM_CPU{NO_IRQ_ID}});

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
      assert_id_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
         (best_id[c*ID_OUT_W +: ID_OUT_W] == NO_IRQ_ID) ||
         (best_id[c*ID_OUT_W +: ID_OUT_W] < ID_OUT_W'(NUM_IRQ)));
   end

endmodule

bind intdist_core intdist_core_chk #(
   .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .CPU_W(CPU_W), .ID_W(ID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_field(reg_field), .reg_id(reg_id),
   .reg_cpu(reg_cpu), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
   .best_id(best_id), .gen_s(gen_s), .gen_ns(gen_ns)
);

// File: tb/intdist_core_tb.sv
module intdist_core_tb;
   import intdist_pkg::*;

   localparam int NC = 2;
   localparam int NI = 64;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          reg_wr = 1'b0, reg_rd = 1'b0;
   logic [0:0]    reg_cpu = '0;
   logic [5:0]    reg_id = '0;
   logic [2:0]    reg_field = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          reg_rvalid;
   logic [31:0]   sgi_req = '0, ppi_in = '0, spi_in = '0;
   logic [19:0]   best_id;
   logic [15:0]   best_prio;

   intdist_core #(.NUM_CPU(NC), .NUM_IRQ(NI)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_cpu(reg_cpu),
      .reg_id(reg_id), .reg_field(reg_field), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .sgi_req(sgi_req), .ppi_in(ppi_in), .spi_in(spi_in),
      .best_id(best_id), .best_prio(best_prio)
   );

   int total = 0;
   int bad = 0;
   int    exp_q[$];
   string tag_q[$];

   // scoreboard monitor: pops one expected item per returned read
   always @(negedge clk) begin
      if (rst_n && reg_rvalid) begin
         int    e;
         string t;
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R2 unrequested read data actual=%0d expected=none", reg_rdata);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (reg_rdata !== DW'(e)) begin
               bad++;
               $display("FAIL %s actual=%0d expected=%0d", t, reg_rdata, e);
            end
         end
      end
   end

   task automatic wr(input int cpu, input int id, input int fld, input int data);
      @(negedge clk);
      reg_wr = 1'b1; reg_cpu = cpu[0:0]; reg_id = id[5:0];
      reg_field = fld[2:0]; reg_wdata = data[7:0];
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int cpu, input int id, input int fld, input int exp, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_cpu = cpu[0:0]; reg_id = id[5:0]; reg_field = fld[2:0];
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chk_best(input int cpu, input int exp, input string tag);
      repeat (2) @(negedge clk);
      total++;
      if (best_id[cpu*10 +: 10] !== 10'(exp)) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, best_id[cpu*10 +: 10], exp);
      end
   endtask

   task automatic chk_prio(input int cpu, input int exp, input string tag);
      total++;
      if (best_prio[cpu*8 +: 8] !== 8'(exp)) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, best_prio[cpu*8 +: 8], exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk_best(0, 1023, "R1 cpu0 idle after reset");
      chk_best(1, 1023, "R1 cpu1 idle after reset");
      chk_prio(0, 255, "R11 idle priority");
      rd(0, 40, FLD_SECURE, 1, "R1 secure after reset");
      rd(0, 0, FLD_GLOBAL, 0, "R1 global switches off");
      rd(1, 5, FLD_PRIO, 0, "R1 priority zero");

      wr(0, 0, FLD_GLOBAL, 1);

      // shared edge interrupt 40 aimed at cpu0
      wr(0, 40, FLD_TRIG, 1);
      rd(0, 40, FLD_TRIG, 1, "R6 trigger writable for shared ID");
      wr(0, 40, FLD_PRIO, 8'h80);
      rd(1, 40, FLD_PRIO, 8'h80, "R2 priority readback next cycle");
      wr(0, 40, FLD_TARGET, 1);
      wr(0, 40, FLD_ENABLE, 1);
      @(negedge clk); spi_in[8] = 1'b1;
      chk_best(0, 40, "R7 rising edge pends shared ID");
      chk_prio(0, 8'h80, "R10 presented priority");
      chk_best(1, 1023, "R4 untargeted cpu sees nothing");
      rd(0, 40, FLD_PEND, 1, "R7 pending after edge");
      wr(0, 40, FLD_PEND, 0);
      rd(0, 40, FLD_PEND, 0, "R7 held input does not re-pend");
      chk_best(0, 1023, "R5 clear-pending on shared ID");
      @(negedge clk); spi_in[8] = 1'b0;
      @(negedge clk); spi_in[8] = 1'b1;
      chk_best(0, 40, "R7 new edge pends again");

      wr(0, 40, FLD_TARGET, 2);
      chk_best(0, 1023, "R4 retarget away from cpu0");
      chk_best(1, 40, "R4 retarget to cpu1");

      // tie and priority ordering on cpu1
      wr(1, 35, FLD_PRIO, 8'h80);
      wr(1, 35, FLD_TARGET, 2);
      wr(1, 35, FLD_TRIG, 1);
      wr(1, 35, FLD_ENABLE, 1);
      wr(1, 35, FLD_PEND, 1);
      chk_best(1, 35, "R10 equal priority lower ID wins");
      wr(1, 50, FLD_PRIO, 8'h10);
      wr(1, 50, FLD_TARGET, 2);
      wr(1, 50, FLD_TRIG, 1);
      wr(1, 50, FLD_ENABLE, 1);
      wr(1, 50, FLD_PEND, 1);
      chk_best(1, 50, "R10 lower value wins");

      // active handling
      wr(0, 50, FLD_ACTIVE, 1);
      chk_best(1, 35, "R9 active not forwarded");
      rd(0, 50, FLD_PEND, 0, "R9 activation clears edge pending");
      rd(0, 50, FLD_ACTIVE, 1, "R9 active readback");
      wr(0, 50, FLD_ACTIVE, 0);
      chk_best(1, 35, "R9 released interrupt stays cleared");

      // private level interrupt 20 in cpu0 bank
      wr(0, 20, FLD_PRIO, 8'h20);
      wr(0, 20, FLD_ENABLE, 1);
      @(negedge clk); ppi_in[4] = 1'b1;
      chk_best(0, 20, "R8 level input pends private ID");
      chk_best(1, 35, "R3 other bank unaffected");
      rd(1, 20, FLD_ENABLE, 0, "R3 cpu1 bank enable");
      rd(0, 20, FLD_ENABLE, 1, "R3 cpu0 bank enable");
      @(negedge clk); ppi_in[4] = 1'b0;
      chk_best(0, 1023, "R8 pending follows falling level");
      rd(0, 20, FLD_PEND, 0, "R8 pending low with input");
      @(negedge clk); ppi_in[4] = 1'b1;
      repeat (2) @(negedge clk);
      wr(0, 20, FLD_ACTIVE, 1);
      @(negedge clk); ppi_in[4] = 1'b0;
      repeat (2) @(negedge clk);
      rd(0, 20, FLD_PEND, 1, "R8 pending held while active");
      chk_best(0, 1023, "R9 active level not forwarded");
      wr(0, 20, FLD_ACTIVE, 0);
      repeat (2) @(negedge clk);
      rd(0, 20, FLD_PEND, 0, "R8 pending resumes tracking");

      // software interrupt 3 in cpu1 bank
      wr(1, 3, FLD_ENABLE, 1);
      @(negedge clk); sgi_req[19] = 1'b1;
      @(negedge clk); sgi_req[19] = 1'b0;
      chk_best(1, 3, "R13 request pends cpu1 software ID");
      chk_prio(1, 0, "R10 priority zero presented");
      rd(0, 3, FLD_PEND, 0, "R13 cpu0 bank untouched");
      wr(1, 3, FLD_PEND, 0);
      rd(1, 3, FLD_PEND, 1, "R5 clear ignored for software ID");
      chk_best(1, 3, "R5 still presented");
      wr(1, 3, FLD_TRIG, 0);
      rd(1, 3, FLD_TRIG, 1, "R6 trigger fixed for software ID");

      wr(1, 20, FLD_TARGET, 3);
      rd(1, 20, FLD_TARGET, 2, "R4 private target read cpu1");
      rd(0, 20, FLD_TARGET, 1, "R4 private target read cpu0");

      // security groups
      wr(1, 3, FLD_SECURE, 0);
      chk_best(1, 35, "R12 non-secure group off");
      wr(0, 0, FLD_GLOBAL, 3);
      rd(0, 0, FLD_GLOBAL, 3, "R2 global readback");
      chk_best(1, 3, "R12 non-secure group on");
      wr(0, 0, FLD_GLOBAL, 2);
      chk_best(1, 3, "R12 non-secure kept when secure off");
      chk_best(0, 1023, "R11 cpu0 none forwardable");
      wr(0, 0, FLD_GLOBAL, 0);
      chk_best(1, 1023, "R12 both groups off");

      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         total++;
         bad++;
         $display("FAIL R2 missing read data actual=%0d expected=0", exp_q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule